// File: doc/BRIEF.md
# Multi-Source Programmable Clock Divider

This block is one clock-generator unit. It picks one of three input clocks (an external oscillator, an input taken from a signal-routing fabric, or the peripheral clock), divides it by a programmable integer, and drives a divided clock whose duty cycle is as close to 50% as an integer split allows. Each input clock is given as a one-cycle tick qualifier on a single reference clock `clk`. The divided output is a registered level on that same reference clock.

Two control bits choose the source. A route-select bit picks the routed input over the oscillator. A separate override bit forces the peripheral clock no matter what the route-select bit says. The routed input comes from a bus of candidates chosen by a 5-bit routing code. One code value names the unit's own output, which may not feed back into the unit, so that code gives a constant low instead.

A new divisor or source only takes effect when the current output period ends. The output therefore never shows a shortened phase. Clearing the enable clears the count and holds the output low.

Top module: `pdiv_unit`

## Requirements
- R1: With `src_periph_ovr`=0 and `src_route_sel`=0, the divider counts ticks of `ext_osc_tick`.
- R2: With `src_periph_ovr`=0 and `src_route_sel`=1, the divider counts ticks of the routed input.
- R3: With `src_periph_ovr`=1, the divider counts ticks of `periph_tick`, whatever the value of `src_route_sel`.
- R4: The routed input is `route_bus[route_code]`. The code 5'h1C (the unit's own output) instead gives a constant 0, so a unit on the routed source stops toggling.
- R5: For an even divisor N≥2, each high phase lasts N/2 source ticks and each low phase lasts N/2 source ticks.
- R6: For an odd divisor N≥3, each high phase lasts (N-1)/2 source ticks and each low phase lasts (N+1)/2 source ticks.
- R7: For a divisor of 0 or 1 with the enable set, `div_clk_out` equals the selected tick from one clock earlier.
- R8: While `div_en` is 0, the count is zero and `div_clk_out` is 0 from the next clock on. One clock after `div_en` rises, the output goes high and a full high phase begins.
- R9: A change of `div_value` or of the source takes effect only at the tick that ends the current output period. The period in progress keeps its old phase lengths.
- R10: After reset, `div_clk_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_osc_tick | input | 1 | External oscillator tick |
| periph_tick | input | 1 | Peripheral clock tick |
| route_bus | input | 32 | Candidate routed ticks, indexed by routing code |
| route_code | input | 5 | Routing code that picks the routed input |
| src_route_sel | input | 1 | 0 selects the oscillator, 1 selects the routed input |
| src_periph_ovr | input | 1 | 1 forces the peripheral clock as the source |
| div_en | input | 1 | Divider enable |
| div_value | input | 8 | Integer divisor |
| div_clk_out | output | 1 | Divided clock |

## Verification
A configuration change and the period-ending tick can fall in the same cycle. The bench provokes this by rewriting the divisor, and later the source, in the first high cycle of a period. It then checks that the running period keeps its old high and low lengths and that the following periods use the new ones. The same collision is covered for the enable: the enable is dropped and raised in the middle of a period, and the bench judges that the output falls at once and that a full high phase follows. Sources tick at rates of 1, 2 and 3 clocks, so the measured phase lengths tell which source is in use.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    typedef enum logic [1:0] {
        SRC_EXT    = 2'd0,
        SRC_ROUTE  = 2'd1,
        SRC_PERIPH = 2'd2
    } src_e;

endpackage

// File: rtl/pdiv_route_mux.sv
module pdiv_route_mux #(
    parameter int          CODE_W    = 5,
    parameter logic [4:0]  SELF_CODE = 5'h1C,
    localparam int         ROUTE_N   = 2 ** CODE_W
) (
    input  logic [ROUTE_N-1:0] route_bus,
    input  logic [CODE_W-1:0]  route_code,
    output logic               route_tick
);

    // The unit's own output may not loop back: that code reads as constant low.
    always_comb begin
        if (route_code == CODE_W'(SELF_CODE)) begin
            route_tick = 1'b0;
        end else begin
            route_tick = route_bus[route_code];
        end
    end

endmodule

// File: rtl/pdiv_src_sel.sv
module pdiv_src_sel
    import pdiv_pkg::*;
(
    input  logic src_route_sel,
    input  logic src_periph_ovr,
    output src_e req_src
);

    always_comb begin
        if (src_periph_ovr) begin
            req_src = SRC_PERIPH;
        end else if (src_route_sel) begin
            req_src = SRC_ROUTE;
        end else begin
            req_src = SRC_EXT;
        end
    end

endmodule

// File: rtl/pdiv_core.sv
module pdiv_core
    import pdiv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] req_div,
    input  src_e             req_src,
    input  logic             ext_tick,
    input  logic             route_tick,
    input  logic             periph_tick,
    output logic             clk_out,
    output logic             sel_tick,
    output logic [DIV_W-1:0] act_cnt,
    output logic [DIV_W-1:0] act_div,
    output src_e             act_src
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

    typedef struct packed {
        logic             run;
        logic             out;
        src_e             src;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;
    logic   tick;
    logic   last;

    always_comb begin
        s_d = s_q;
        unique case (s_q.src)
            SRC_EXT:   tick = ext_tick;
            SRC_ROUTE: tick = route_tick;
            default:   tick = periph_tick;
        endcase
        last = (s_q.cnt == s_q.div - ONE);

        if (!en) begin
            // Idle: clear and track the requested setup directly.
            s_d.run = 1'b0;
            s_d.out = 1'b0;
            s_d.cnt = '0;
            s_d.div = req_div;
            s_d.src = req_src;
        end else if (s_q.div < TWO) begin
            // Undivided: every cycle is a period boundary.
            s_d.run = 1'b1;
            s_d.out = tick;
            s_d.cnt = '0;
            s_d.div = req_div;
            s_d.src = req_src;
        end else if (!s_q.run) begin
            // First enabled cycle opens a full high phase.
            s_d.run = 1'b1;
            s_d.out = 1'b1;
        end else begin
            if (tick) begin
                if (last) begin
                    s_d.cnt = '0;
                    s_d.div = req_div;
                    s_d.src = req_src;
                end else begin
                    s_d.cnt = s_q.cnt + ONE;
                end
            end
            // High for floor(N/2) ticks, low for the rest.
            s_d.out = (s_d.div >= TWO) && (s_d.cnt < (s_d.div >> 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{run: 1'b0, out: 1'b0, src: SRC_EXT, div: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_out  = s_q.out;
    assign sel_tick = tick;
    assign act_cnt  = s_q.cnt;
    assign act_div  = s_q.div;
    assign act_src  = s_q.src;

endmodule

// File: rtl/pdiv_unit.sv
module pdiv_unit
    import pdiv_pkg::*;
#(
    parameter int          DIV_W     = 8,
    parameter int          CODE_W    = 5,
    parameter logic [4:0]  SELF_CODE = 5'h1C,
    localparam int         ROUTE_N   = 2 ** CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_osc_tick,
    input  logic               periph_tick,
    input  logic [ROUTE_N-1:0] route_bus,
    input  logic [CODE_W-1:0]  route_code,
    input  logic               src_route_sel,
    input  logic               src_periph_ovr,
    input  logic               div_en,
    input  logic [DIV_W-1:0]   div_value,
    output logic               div_clk_out
);

    logic             route_tick;
    src_e             req_src;
    logic             sel_tick;
    logic [DIV_W-1:0] act_cnt;
    logic [DIV_W-1:0] act_div;
    src_e             act_src;

    pdiv_route_mux #(
        .CODE_W    (CODE_W),
        .SELF_CODE (SELF_CODE)
    ) u_route (
        .route_bus  (route_bus),
        .route_code (route_code),
        .route_tick (route_tick)
    );

    pdiv_src_sel u_src (
        .src_route_sel  (src_route_sel),
        .src_periph_ovr (src_periph_ovr),
        .req_src        (req_src)
    );

    pdiv_core #(
        .DIV_W (DIV_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (div_en),
        .req_div     (div_value),
        .req_src     (req_src),
        .ext_tick    (ext_osc_tick),
        .route_tick  (route_tick),
        .periph_tick (periph_tick),
        .clk_out     (div_clk_out),
        .sel_tick    (sel_tick),
        .act_cnt     (act_cnt),
        .act_div     (act_div),
        .act_src     (act_src)
    );

endmodule

// File: rtl/pdiv_unit_chk.sv
module pdiv_unit_chk
    import pdiv_pkg::*;
#(
    parameter int          DIV_W     = 8,
    parameter int          CODE_W    = 5,
    parameter logic [4:0]  SELF_CODE = 5'h1C
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_en,
    input logic             src_periph_ovr,
    input logic [CODE_W-1:0] route_code,
    input logic             route_tick,
    input logic             sel_tick,
    input logic [DIV_W-1:0] act_cnt,
    input logic [DIV_W-1:0] act_div,
    input src_e             act_src,
    input logic             div_clk_out
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

    AST_OVR_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && src_periph_ovr && act_div >= TWO && sel_tick && act_cnt == act_div - ONE)
        |=> (act_src == SRC_PERIPH)); // R3

    AST_OVR_UNDIVIDED: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && src_periph_ovr && act_div < TWO) |=> (act_src == SRC_PERIPH)); // R3

    AST_SELF_CODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (route_code == CODE_W'(SELF_CODE)) |-> !route_tick); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div >= TWO) |-> (act_cnt < act_div)); // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && $past(div_en) && act_div >= TWO && $past(act_div) >= TWO && !sel_tick)
        |=> $stable(div_clk_out)); // R6

    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && act_div < TWO) |=> (div_clk_out == $past(sel_tick))); // R7

    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |=> (!div_clk_out && act_cnt == '0)); // R8

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && act_div >= TWO && !(sel_tick && act_cnt == act_div - ONE))
        |=> (act_div == $past(act_div))); // R9

endmodule

bind pdiv_unit pdiv_unit_chk #(
    .DIV_W     (DIV_W),
    .CODE_W    (CODE_W),
    .SELF_CODE (SELF_CODE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .div_en         (div_en),
    .src_periph_ovr (src_periph_ovr),
    .route_code     (route_code),
    .route_tick     (route_tick),
    .sel_tick       (sel_tick),
    .act_cnt        (act_cnt),
    .act_div        (act_div),
    .act_src        (act_src),
    .div_clk_out    (div_clk_out)
);

// File: tb/pdiv_unit_bench.sv
module pdiv_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_osc_tick = 1'b1;
    logic        periph_tick = 1'b0;
    logic [31:0] route_bus = 32'hFFFF_FFDF;
    logic [4:0]  route_code = 5'd5;
    logic        src_route_sel = 1'b0;
    logic        src_periph_ovr = 1'b0;
    logic        div_en = 1'b0;
    logic [7:0]  div_value = 8'd4;
    logic        div_clk_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ph2 = 0;
    int ph3 = 0;
    logic periph_seen = 1'b0;
    logic route5_seen = 1'b0;

    always #2 clk = ~clk;

    pdiv_unit u_pdiv_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .ext_osc_tick   (ext_osc_tick),
        .periph_tick    (periph_tick),
        .route_bus      (route_bus),
        .route_code     (route_code),
        .src_route_sel  (src_route_sel),
        .src_periph_ovr (src_periph_ovr),
        .div_en         (div_en),
        .div_value      (div_value),
        .div_clk_out    (div_clk_out)
    );

    // Tick sources: oscillator every clock, route_bus[5] every 2, peripheral every 3.
    always @(posedge clk) begin
        periph_seen = periph_tick;
        route5_seen = route_bus[5];
        #1;
        ph2 = (ph2 + 1) % 2;
        ph3 = (ph3 + 1) % 3;
        route_bus[5] = (ph2 == 0);
        periph_tick  = (ph3 == 0);
    end

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cyc);
            finish_up();
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic prev;
        prev = div_clk_out;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!prev && div_clk_out) return;
            prev = div_clk_out;
        end
    endtask

    // Called in the first high cycle; returns in the first high cycle of the next period.
    task automatic count_phases(output int hi, output int lo);
        hi = 1;
        lo = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!div_clk_out) break;
            hi++;
        end
        lo = 1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (div_clk_out) break;
            lo++;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        wait_rise();
        count_phases(hi, lo);
    endtask

    task automatic setup(int n, int sel, int ovr, int code);
        @(negedge clk);
        div_en = 1'b0;
        div_value = 8'(n);
        src_route_sel = sel[0];
        src_periph_ovr = ovr[0];
        route_code = 5'(code);
        @(negedge clk);
        @(negedge clk);
        div_en = 1'b1;
    endtask

    initial begin
        int hi, lo, k, chg;
        logic held;

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 out during reset", int'(div_clk_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 out after reset", int'(div_clk_out), 0);

        // R1 R2 R3 R5 R6: sweep sources and divisors
        for (int s = 0; s < 3; s++) begin
            for (int n = 2; n <= 9; n++) begin
                k = s + 1;
                setup(n, (s == 1) ? 1 : 0, (s == 2) ? 1 : 0, 5);
                measure(hi, lo);
                measure(hi, lo);
                if (n % 2 == 0) begin
                    check($sformatf("R5 high src%0d N=%0d", s, n), hi, (n / 2) * k);
                    check($sformatf("R5 low src%0d N=%0d", s, n), lo, (n / 2) * k);
                end else begin
                    check($sformatf("R6 high src%0d N=%0d", s, n), hi, ((n - 1) / 2) * k);
                    check($sformatf("R6 low src%0d N=%0d", s, n), lo, ((n + 1) / 2) * k);
                end
                if (s == 0) check($sformatf("R1 period N=%0d", n), hi + lo, n);
                if (s == 1) check($sformatf("R2 period N=%0d", n), hi + lo, 2 * n);
                if (s == 2) check($sformatf("R3 period N=%0d", n), hi + lo, 3 * n);
            end
        end

        // R3: override wins over the route-select bit
        setup(4, 1, 1, 5);
        measure(hi, lo);
        measure(hi, lo);
        check("R3 override with route sel", hi + lo, 12);

        // R4: a different code decodes its own bus bit (bit 27 ticks every clock)
        setup(4, 1, 0, 27);
        measure(hi, lo);
        measure(hi, lo);
        check("R4 code 27 high", hi, 2);
        check("R4 code 27 low", lo, 2);

        // R4: the self code 5'h1C reads as low even though route_bus[28] is 1
        route_code = 5'h1C;
        repeat (6) @(negedge clk);
        held = div_clk_out;
        chg = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (div_clk_out != held) chg++;
        end
        check("R4 self code frozen output", chg, 0);
        route_code = 5'd5;
        chg = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (div_clk_out != held) chg++;
        end
        check("R4 route restored toggles", int'(chg > 0), 1);

        // R9: divisor change in the first high cycle of a period
        setup(4, 0, 0, 5);
        wait_rise();
        wait_rise();
        div_value = 8'd6;
        count_phases(hi, lo);
        check("R9 old period high", hi, 2);
        check("R9 old period low", lo, 2);
        count_phases(hi, lo);
        check("R9 new period high", hi, 3);
        check("R9 new period low", lo, 3);

        // R9: source change lands at the boundary (oscillator -> route k=2)
        src_route_sel = 1'b1;
        count_phases(hi, lo);
        check("R9 old source high", hi, 3);
        check("R9 old source low", lo, 3);
        count_phases(hi, lo);
        count_phases(hi, lo);
        check("R9 new source high", hi, 6);
        check("R9 new source low", lo, 6);

        // R8: enable drop and restart
        setup(4, 0, 0, 5);
        wait_rise();
        @(negedge clk);
        div_en = 1'b0;
        @(negedge clk);
        check("R8 out low after disable", int'(div_clk_out), 0);
        chg = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (div_clk_out) chg++;
        end
        check("R8 out held low", chg, 0);
        div_en = 1'b1;
        @(negedge clk);
        check("R8 out high after enable", int'(div_clk_out), 1);
        count_phases(hi, lo);
        check("R8 first high full", hi, 2);
        check("R8 first low full", lo, 2);

        // R7: undivided pass-through, divisor 1 on peripheral, divisor 0 on route
        setup(1, 0, 1, 5);
        repeat (3) @(negedge clk);
        chg = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (div_clk_out != periph_seen) chg++;
        end
        check("R7 divisor 1 follows peripheral", chg, 0);
        setup(0, 1, 0, 5);
        repeat (3) @(negedge clk);
        chg = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (div_clk_out != route5_seen) chg++;
        end
        check("R7 divisor 0 follows route", chg, 0);

        finish_up();
    end

endmodule